// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block collects up to 32 interrupt lines and turns them into two request outputs and one wake output. Each line is first brought into the local clock domain. It is then judged against a 3-bit trigger code that selects rising-edge, falling-edge, either-edge, active-high level or active-low level detection. The code can also switch the line off. Edges are held in two capture registers until software clears them. Level conditions follow the synchronized line directly and are not stored.

Software configures the block through a word-addressed register bus. Every configuration register has two addresses. At one address, written ones set bits. At the other, written ones clear bits. Written zeros change nothing, so one source can be updated without a read-modify-write. Per source, an enable bit gates the request outputs and a route bit picks request 0 or request 1. A wake bit lets the source drive the wake output, and a source-select bit connects or disconnects the input line. Two read-only status words show the pending, enabled sources on each request output.

Top module: `irq_ctl`

## Requirements
- R1: After reset, the three trigger-code words, the enable word, the wake word and both capture words read 0. The route word and the source-select word read all ones. `req0_o`, `req1_o` and `wake_o` are low.
- R2: Configuration words sit at address pairs: code bit 0 at 0/1, code bit 1 at 2/3, code bit 2 at 4/5, enable at 6/7, route at 8/9, wake at 10/11 and source-select at 12/13. The even address sets every bit written as 1 and the odd address clears it. Bits written as 0 keep their value. A read at either address of a pair returns the stored word.
- R3: Code 001 (bit 0 only) latches a rising edge of the synchronized line into the rising-capture word (read at 14). The source stays pending after the line falls again.
- R4: Code 010 (bit 1 only) latches a falling edge into the falling-capture word (read at 15). A rising edge alone leaves the source idle.
- R5: Code 011 makes a source pending on either edge, each held in its own capture word.
- R6: Code 101 makes a source pending while its synchronized line is high, and nothing is latched.
- R7: Code 110 makes a source pending while its synchronized line is low.
- R8: Codes 000, 100 and 111 never make a source pending and never set a capture bit.
- R9: A pending, enabled source with route bit 1 drives `req0_o` and shows in the status word at 16. With route bit 0 it drives `req1_o` and shows in the status word at 17.
- R10: A source whose enable bit is 0 drives neither request output nor either status word.
- R11: `wake_o` is the OR of all pending sources whose wake bit is 1, whatever their enable bit.
- R12: Writing ones to address 14 or 15 clears those bits of the rising- or falling-capture word. This withdraws the pending state the bits caused.
- R13: A source whose source-select bit is 0 is never pending and captures no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Raw interrupt lines, one per source |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data, one bit per source |
| bus_we | input | 1 | Write strobe, applied at the clock edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| req0_o | output | 1 | Request output 0 |
| req1_o | output | 1 | Request output 1 |
| wake_o | output | 1 | Wake output |

## Verification
The bound checker watches several things on every cycle. A request output may only be high when some source is both enabled and routed to it. No request output may be high while the enable word is zero. Wake may only be high when some wake bit is set. The enable and route words must not change in a cycle without a write, and the reset values must hold on leaving reset.

Some behaviours only the bench scenarios can show. These are what each trigger code does with real line transitions and how long captured edges stay pending. They also include the set and clear semantics at each address and the effect of the source-select bit. Each of these is tested by driving lines and reading the capture and status words back.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int ADDR_W = 5;

    // register pair index k: set address 2k, clear address 2k+1
    localparam int NREG   = 7;
    localparam int RG_C0  = 0;
    localparam int RG_C1  = 1;
    localparam int RG_C2  = 2;
    localparam int RG_EN  = 3;
    localparam int RG_RT  = 4;
    localparam int RG_WK  = 5;
    localparam int RG_SR  = 6;

    localparam logic [ADDR_W-1:0] A_RCAP = 5'd14;
    localparam logic [ADDR_W-1:0] A_FCAP = 5'd15;
    localparam logic [ADDR_W-1:0] A_ST0  = 5'd16;
    localparam logic [ADDR_W-1:0] A_ST1  = 5'd17;

    typedef struct packed {
        logic rise;
        logic fall;
        logic hi;
        logic lo;
    } trig_t;

    // {bit2,bit1,bit0} trigger code to detection enables
    function automatic trig_t decode_mode(input logic [2:0] m);
        trig_t t;
        t = '0;
        case (m)
            3'b001: t.rise = 1'b1;
            3'b010: t.fall = 1'b1;
            3'b011: begin t.rise = 1'b1; t.fall = 1'b1; end
            3'b101: t.hi = 1'b1;
            3'b110: t.lo = 1'b1;
            default: t = '0;
        endcase
        return t;
    endfunction

    function automatic logic reset_ones(input int k);
        return (k == RG_RT) || (k == RG_SR);
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise_ev,
    output logic [W-1:0] fall_ev
);
    logic [W-1:0] s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= '0;
        end else begin
            s1_q   <= raw;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign lvl     = s2_q;
    assign rise_ev = s2_q & ~prev_q;
    assign fall_ev = ~s2_q & prev_q;
endmodule

// File: rtl/irqc_bitreg.sv
module irqc_bitreg #(
    parameter int   W       = 32,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= {W{RST_VAL}};
        else if (set_we) q <= q | wdata;
        else if (clr_we) q <= q & ~wdata;
    end
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend
    import irqc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] c0,
    input  logic [W-1:0] c1,
    input  logic [W-1:0] c2,
    input  logic [W-1:0] src,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] rcap,
    input  logic [W-1:0] fcap,
    output logic [W-1:0] arm_rise,
    output logic [W-1:0] arm_fall,
    output logic [W-1:0] pend
);
    for (genvar i = 0; i < W; i++) begin : g_src
        trig_t t;
        assign t           = decode_mode({c2[i], c1[i], c0[i]});
        assign arm_rise[i] = src[i] & t.rise;
        assign arm_fall[i] = src[i] & t.fall;
        assign pend[i]     = src[i] & ((t.rise & rcap[i]) | (t.fall & fcap[i]) |
                                       (t.hi & lvl[i]) | (t.lo & ~lvl[i]));
    end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
    import irqc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      irq_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    input  logic              bus_we,
    output logic [N-1:0]      bus_rdata,
    output logic              req0_o,
    output logic              req1_o,
    output logic              wake_o
);
    logic [N-1:0] regq [NREG];
    logic [N-1:0] lvl, rise_ev, fall_ev;
    logic [N-1:0] arm_rise, arm_fall, pend;
    logic [N-1:0] rcap_q, fcap_q;
    logic [N-1:0] en_q, route_q, wake_q;
    logic [N-1:0] st0, st1;

    irqc_sync #(.W(N)) u_sync (
        .clk(clk), .rst(rst), .raw(irq_in),
        .lvl(lvl), .rise_ev(rise_ev), .fall_ev(fall_ev)
    );

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(2 * k);
        localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(2 * k + 1);
        irqc_bitreg #(.W(N), .RST_VAL(reset_ones(k))) u_r (
            .clk(clk), .rst(rst),
            .set_we(bus_we && bus_addr == SET_A),
            .clr_we(bus_we && bus_addr == CLR_A),
            .wdata(bus_wdata), .q(regq[k])
        );
    end

    assign en_q    = regq[RG_EN];
    assign route_q = regq[RG_RT];
    assign wake_q  = regq[RG_WK];

    irqc_pend #(.W(N)) u_pend (
        .c0(regq[RG_C0]), .c1(regq[RG_C1]), .c2(regq[RG_C2]), .src(regq[RG_SR]),
        .lvl(lvl), .rcap(rcap_q), .fcap(fcap_q),
        .arm_rise(arm_rise), .arm_fall(arm_fall), .pend(pend)
    );

    // capture words: a new edge in the same cycle wins over a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            rcap_q <= '0;
            fcap_q <= '0;
        end else begin
            rcap_q <= (rcap_q & ~((bus_we && bus_addr == A_RCAP) ? bus_wdata : '0))
                      | (rise_ev & arm_rise);
            fcap_q <= (fcap_q & ~((bus_we && bus_addr == A_FCAP) ? bus_wdata : '0))
                      | (fall_ev & arm_fall);
        end
    end

    assign st0    = pend & en_q & route_q;
    assign st1    = pend & en_q & ~route_q;
    assign req0_o = |st0;
    assign req1_o = |st1;
    assign wake_o = |(pend & wake_q);

    always_comb begin
        case (bus_addr)
            5'd0,  5'd1:  bus_rdata = regq[RG_C0];
            5'd2,  5'd3:  bus_rdata = regq[RG_C1];
            5'd4,  5'd5:  bus_rdata = regq[RG_C2];
            5'd6,  5'd7:  bus_rdata = regq[RG_EN];
            5'd8,  5'd9:  bus_rdata = regq[RG_RT];
            5'd10, 5'd11: bus_rdata = regq[RG_WK];
            5'd12, 5'd13: bus_rdata = regq[RG_SR];
            A_RCAP:       bus_rdata = rcap_q;
            A_FCAP:       bus_rdata = fcap_q;
            A_ST0:        bus_rdata = st0;
            A_ST1:        bus_rdata = st1;
            default:      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_we,
    input logic         req0_o,
    input logic         req1_o,
    input logic         wake_o,
    input logic [N-1:0] en_q,
    input logic [N-1:0] route_q,
    input logic [N-1:0] wake_q
);
    // R1: reset values seen on leaving reset
    p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == '0 && route_q == '1 && wake_q == '0 && !req0_o && !req1_o));

    // R2: configuration only moves on a write
    p_hold_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_we) |-> ($stable(en_q) && $stable(route_q) && $stable(wake_q)));

    // R9: a request output needs an enabled source routed to it
    p_req0_route_r9: assert property (@(posedge clk) disable iff (rst)
        req0_o |-> |(en_q & route_q));
    p_req1_route_r9: assert property (@(posedge clk) disable iff (rst)
        req1_o |-> |(en_q & ~route_q));

    // R10: nothing enabled, no request
    p_en_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> (!req0_o && !req1_o));

    // R11: wake needs a wake bit
    p_wake_src_r11: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> |wake_q);
endmodule

bind irq_ctl irq_ctl_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we),
    .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o),
    .en_q(en_q), .route_q(route_q), .wake_q(wake_q)
);

// File: tb/irq_ctl_bench.sv
module irq_ctl_bench;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_in = '0;
    logic [4:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [N-1:0]  bus_rdata;
    logic          req0_o, req1_o, wake_o;

    always #2 clk = ~clk;

    irq_ctl #(.N(N)) u_irq_ctl (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
    );

    typedef struct {
        int          kind;   // 0 rdata, 1 req0, 2 req1, 3 wake
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  mon_ev;
    int    checks = 0;
    int    failures = 0;
    bit    done = 0;

    // monitor: pops expected items and compares
    always begin
        @(mon_ev);
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = bus_rdata;
                1: act = {31'b0, req0_o};
                2: act = {31'b0, req1_o};
                default: act = {31'b0, wake_o};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        q.push_back(it);
        ->mon_ev;
        @(posedge clk);
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        push(0, e, tag);
    endtask

    task automatic out(input int kind, input bit e, input string tag);
        @(negedge clk);
        push(kind, {31'b0, e}, tag);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic line(input int i, input bit v);
        @(negedge clk);
        irq_in[i] = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        rd(0,  32'h0, "R1 code bit0 word");
        rd(5,  32'h0, "R1 code bit2 word");
        rd(6,  32'h0, "R1 enable word");
        rd(8,  32'hFFFFFFFF, "R1 route word");
        rd(10, 32'h0, "R1 wake word");
        rd(12, 32'hFFFFFFFF, "R1 source-select word");
        rd(14, 32'h0, "R1 rise capture");
        rd(15, 32'h0, "R1 fall capture");
        out(1, 0, "R1 req0");
        out(2, 0, "R1 req1");
        out(3, 0, "R1 wake");
        // R2
        wr(0, 32'hF0);  rd(1, 32'hF0, "R2 set then read clear addr");
        wr(1, 32'h30);  rd(0, 32'hC0, "R2 clear selected bits");
        wr(0, 32'h0);   rd(0, 32'hC0, "R2 zero write keeps bits");
        wr(1, 32'hFFFFFFFF); rd(0, 32'h0, "R2 clear all");
        // R3 source 3 rising, route req0
        wr(0, 32'h8); wr(6, 32'h8);
        out(1, 0, "R3 idle before edge");
        line(3, 1);
        out(1, 1, "R3 rising edge pending");
        rd(14, 32'h8, "R3 rise capture bit");
        line(3, 0);
        out(1, 1, "R3 stays pending after fall");
        rd(16, 32'h8, "R9 status req0");
        wr(14, 32'h8);
        out(1, 0, "R12 rise clear drops req0");
        rd(14, 32'h0, "R12 rise capture cleared");
        // R4 source 5 falling, route req1
        wr(2, 32'h20); wr(9, 32'h20); wr(6, 32'h20);
        line(5, 1);
        out(2, 0, "R4 rising edge ignored");
        line(5, 0);
        out(2, 1, "R4 falling edge pending");
        rd(17, 32'h20, "R9 status req1");
        out(1, 0, "R9 req0 quiet for req1 source");
        wr(15, 32'h20);
        out(2, 0, "R12 fall clear drops req1");
        // R5 source 7 both edges
        wr(0, 32'h80); wr(2, 32'h80); wr(6, 32'h80);
        line(7, 1);
        out(1, 1, "R5 rise pending");
        rd(14, 32'h80, "R5 rise capture");
        wr(14, 32'h80);
        out(1, 0, "R5 rise cleared");
        line(7, 0);
        out(1, 1, "R5 fall pending");
        rd(15, 32'h80, "R5 fall capture");
        wr(15, 32'h80);
        out(1, 0, "R5 fall cleared");
        // R6 source 9 high level
        wr(4, 32'h200); wr(0, 32'h200); wr(6, 32'h200);
        out(1, 0, "R6 low line idle");
        line(9, 1);
        out(1, 1, "R6 high line pending");
        rd(14, 32'h0, "R6 nothing latched");
        line(9, 0);
        out(1, 0, "R6 follows line low");
        // R7 source 11 low level
        wr(4, 32'h800); wr(2, 32'h800); wr(6, 32'h800);
        out(1, 1, "R7 low line pending");
        line(11, 1);
        out(1, 0, "R7 high line idle");
        // R8 codes 100, 111, 000
        wr(4, 32'h2000); wr(6, 32'h2000);
        line(13, 1);
        out(1, 0, "R8 code 100 idle");
        wr(0, 32'h4000); wr(2, 32'h4000); wr(4, 32'h4000); wr(6, 32'h4000);
        line(14, 1); line(14, 0);
        out(1, 0, "R8 code 111 idle");
        rd(14, 32'h0, "R8 no rise capture");
        rd(15, 32'h0, "R8 no fall capture");
        wr(6, 32'h8000);
        line(15, 1); line(15, 0);
        out(1, 0, "R8 code 000 idle");
        rd(16, 32'h0, "R8 status req0 empty");
        // R10 enable gating on source 9
        line(9, 1);
        out(1, 1, "R10 enabled high level");
        wr(7, 32'h200);
        out(1, 0, "R10 disabled source no req0");
        rd(16, 32'h0, "R10 status req0 empty");
        // R11 wake ignores enable
        wr(10, 32'h200);
        out(3, 1, "R11 wake from disabled source");
        wr(11, 32'h200);
        out(3, 0, "R11 wake bit cleared");
        // R13 source select
        wr(6, 32'h200);
        out(1, 1, "R13 source connected");
        wr(13, 32'h200);
        out(1, 0, "R13 source disconnected");
        rd(16, 32'h0, "R13 status empty");
        wr(12, 32'h200);
        out(1, 1, "R13 source reconnected");
        wr(13, 32'h8);
        line(3, 1);
        rd(14, 32'h0, "R13 no capture when disconnected");
        // R9 reroute source 9 to req1
        wr(9, 32'h200);
        out(2, 1, "R9 rerouted req1");
        out(1, 0, "R9 rerouted req0 off");
        rd(17, 32'h200, "R9 status req1 after reroute");
        repeat (2) @(negedge clk);
        done = 1;
        summary();
    end
endmodule